// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block generates the instruction address for a small 8-bit controller core. It holds a 13-bit logical counter, so the address space seen by software is 8K words. Only 2K words of program storage exist, so the fetch address sent to program memory keeps just the low 11 bits of the counter. Any logical address above 07FFh therefore lands on the matching location in the first 2K.

The core's decode logic drives single-cycle strobes. They can advance to the next instruction, jump to a target, call a subroutine at a target, return from a subroutine, or accept an interrupt. Call and interrupt store an address on a hidden 8-slot return stack. Any kind of return restores the most recent stored address. Software cannot see the stack pointer. It wraps in both directions and raises no error flag. Every change of the counter shows at the outputs on the clock edge after the strobe.

Top module: `fetch_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_value` is 0000h and the stack pointer and every stack slot are zero, whatever the strobes do. A return issued straight after reset loads 0000h.
- R2: `fetch_addr` always equals bits [10:0] of `pc_value`, so logical addresses 0800h–1FFFh fetch from the matching location below 0800h.
- R3: `step_en` alone sets the counter to its old value plus one, modulo 2000h, so 1FFFh is followed by 0000h.
- R4: `jump_en` loads `target` into the counter without touching the stack.
- R5: `irq_ack` saves the current counter value on the stack and loads 0004h.
- R6: `call_en` saves the counter value plus one (modulo 2000h) on the stack and loads `target`.
- R7: `ret_en` loads the most recently saved address and removes it from the stack. The stack is last-in first-out and holds up to 8 nested addresses.
- R8: A ninth save with no return in between overwrites the oldest slot. The stack is circular, so a return from an empty stack wraps to the slot that was written 8 saves earlier.
- R9: When several strobes are high in the same cycle, reset wins, then `irq_ack`, then `ret_en`, then `call_en`, then `jump_en`, then `step_en`. Only the winning action takes effect.
- R10: With no strobe high, the counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance to the next address |
| jump_en | input | 1 | Load `target` |
| call_en | input | 1 | Save the address of the next instruction, then load `target` |
| ret_en | input | 1 | Restore the last saved address |
| irq_ack | input | 1 | Interrupt accepted: save the counter, load the interrupt vector |
| target | input | 13 | Destination for jump and call |
| pc_value | output | 13 | Full logical counter |
| fetch_addr | output | 11 | Physical program-memory address |

## Verification
A wrong stack pointer or a corrupted slot does not show when the call or interrupt happens. It shows only later, as a wrong `pc_value` in the cycle after the matching return. The bench therefore checks every return against a model in the bench, at nesting depths up to 8 and across overflow. A fault in the increment or fold logic shows at once as a wrong `pc_value` or `fetch_addr` one edge after the strobe. The full 8K sweep reaches each of these addresses, including the rollover from 1FFFh.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   // winning action for one cycle, chosen by the arbiter
   typedef enum logic [2:0] {
      ACT_HOLD,
      ACT_STEP,
      ACT_JUMP,
      ACT_CALL,
      ACT_RET,
      ACT_IRQ
   } fseq_act_e;

endpackage

// File: rtl/fseq_arbiter.sv
module fseq_arbiter
   import fseq_pkg::*;
(
   input  logic      step_en,
   input  logic      jump_en,
   input  logic      call_en,
   input  logic      ret_en,
   input  logic      irq_ack,
   output fseq_act_e act,
   output logic      push,
   output logic      pop
);

   always_comb begin
      if (irq_ack)      act = ACT_IRQ;
      else if (ret_en)  act = ACT_RET;
      else if (call_en) act = ACT_CALL;
      else if (jump_en) act = ACT_JUMP;
      else if (step_en) act = ACT_STEP;
      else              act = ACT_HOLD;
   end

   assign push = (act == ACT_IRQ) || (act == ACT_CALL);
   assign pop  = (act == ACT_RET);

endmodule

// File: rtl/fseq_stack.sv
module fseq_stack #(
   parameter int W     = 13,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_data,
   output logic [W-1:0] top_data
);

   localparam int SP_W = $clog2(DEPTH);
   localparam logic [SP_W-1:0] ONE = SP_W'(1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("fseq_stack: DEPTH must be a power of two and at least 2");
      end
   endgenerate

   logic [W-1:0]    slot [DEPTH];
   logic [SP_W-1:0] sp;

   // sp points to the next free slot; the top entry sits one below
   assign top_data = slot[sp - ONE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= '0;
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else if (push) begin
         slot[sp] <= push_data;
         sp       <= sp + ONE;
      end else if (pop) begin
         sp <= sp - ONE;
      end
   end

endmodule

// File: rtl/fseq_counter.sv
module fseq_counter
   import fseq_pkg::*;
#(
   parameter int             PC_W    = 13,
   parameter int             PHYS_W  = 11,
   parameter logic [PC_W-1:0] RST_VEC = '0,
   parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fseq_act_e         act,
   input  logic [PC_W-1:0]   target,
   input  logic [PC_W-1:0]   restore,
   output logic [PC_W-1:0]   pc,
   output logic [PC_W-1:0]   pc_inc,
   output logic [PHYS_W-1:0] phys
);

   logic [PC_W-1:0] pc_nxt;

   assign pc_inc = pc + PC_W'(1);

   always_comb begin
      unique case (act)
         ACT_IRQ:  pc_nxt = IRQ_VEC;
         ACT_RET:  pc_nxt = restore;
         ACT_CALL: pc_nxt = target;
         ACT_JUMP: pc_nxt = target;
         ACT_STEP: pc_nxt = pc_inc;
         default:  pc_nxt = pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= RST_VEC;
      else        pc <= pc_nxt;
   end

   // fold the logical space onto the implemented memory
   generate
      if (PHYS_W == PC_W) begin : g_full
         assign phys = pc;
      end else begin : g_fold
         assign phys = pc[PHYS_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
   import fseq_pkg::*;
#(
   parameter int PC_W   = 13,
   parameter int PHYS_W = 11,
   parameter int DEPTH  = 8,
   parameter int IRQ_AT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              jump_en,
   input  logic              call_en,
   input  logic              ret_en,
   input  logic              irq_ack,
   input  logic [PC_W-1:0]   target,
   output logic [PC_W-1:0]   pc_value,
   output logic [PHYS_W-1:0] fetch_addr
);

   localparam logic [PC_W-1:0] IRQ_VEC = PC_W'(IRQ_AT);

   generate
      if (PHYS_W < 1 || PHYS_W > PC_W) begin : g_bad_phys
         $error("fetch_sequencer: PHYS_W must lie in 1..PC_W");
      end
      if (IRQ_AT < 0 || IRQ_AT >= (1 << PHYS_W)) begin : g_bad_vec
         $error("fetch_sequencer: IRQ_AT must be inside the implemented space");
      end
   endgenerate

   fseq_act_e       act;
   logic            push, pop;
   logic [PC_W-1:0] pc_inc, top_data, push_data;

   fseq_arbiter u_arb (
      .step_en (step_en),
      .jump_en (jump_en),
      .call_en (call_en),
      .ret_en  (ret_en),
      .irq_ack (irq_ack),
      .act     (act),
      .push    (push),
      .pop     (pop)
   );

   // interrupt saves the address not yet executed; call saves the next one
   assign push_data = (act == ACT_IRQ) ? pc_value : pc_inc;

   fseq_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (push_data),
      .top_data  (top_data)
   );

   fseq_counter #(
      .PC_W    (PC_W),
      .PHYS_W  (PHYS_W),
      .RST_VEC ('0),
      .IRQ_VEC (IRQ_VEC)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .target  (target),
      .restore (top_data),
      .pc      (pc_value),
      .pc_inc  (pc_inc),
      .phys    (fetch_addr)
   );

endmodule

// File: rtl/fetch_sequencer_chk.sv
module fetch_sequencer_chk #(
   parameter int PC_W   = 13,
   parameter int PHYS_W = 11,
   parameter int IRQ_AT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_en,
   input logic              jump_en,
   input logic              call_en,
   input logic              ret_en,
   input logic              irq_ack,
   input logic [PC_W-1:0]   target,
   input logic [PC_W-1:0]   pc_value,
   input logic [PHYS_W-1:0] fetch_addr
);

   p_irq_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> pc_value == PC_W'(IRQ_AT));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !jump_en && !call_en && !ret_en && !irq_ack)
      |=> pc_value == $past(pc_value) + PC_W'(1));

   p_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_en && !call_en && !ret_en && !irq_ack)
      |=> pc_value == $past(target));

   p_call_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (call_en && !ret_en && !irq_ack) |=> pc_value == $past(target));

   // R7: a return right after a call lands on the instruction after the call
   p_call_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (call_en && !ret_en && !irq_ack) ##1 (ret_en && !irq_ack)
      |=> pc_value == $past(pc_value, 2) + PC_W'(1));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !jump_en && !call_en && !ret_en && !irq_ack)
      |=> $stable(pc_value));

   // R2: the fetch address follows the counter's low bits
   p_fold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_addr == pc_value[PHYS_W-1:0]);

endmodule

bind fetch_sequencer fetch_sequencer_chk #(
   .PC_W   (PC_W),
   .PHYS_W (PHYS_W),
   .IRQ_AT (IRQ_AT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .step_en    (step_en),
   .jump_en    (jump_en),
   .call_en    (call_en),
   .ret_en     (ret_en),
   .irq_ack    (irq_ack),
   .target     (target),
   .pc_value   (pc_value),
   .fetch_addr (fetch_addr)
);

// File: tb/test_fetch_sequencer.sv
`timescale 1ns/1ps
module test_fetch_sequencer;

   localparam int PC_W   = 13;
   localparam int PHYS_W = 11;
   localparam int DEPTH  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              step_en = 1'b0, jump_en = 1'b0, call_en = 1'b0;
   logic              ret_en = 1'b0, irq_ack = 1'b0;
   logic [PC_W-1:0]   target = '0;
   logic [PC_W-1:0]   pc_value;
   logic [PHYS_W-1:0] fetch_addr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench model of the counter and stack, built from the requirements
   logic [PC_W-1:0] exp_pc = '0;
   logic [PC_W-1:0] mdl [DEPTH];
   int              msp = 0;

   always #2 clk = ~clk;   // 250 MHz

   fetch_sequencer i_fetch_sequencer (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_en(jump_en),
      .call_en(call_en), .ret_en(ret_en), .irq_ack(irq_ack),
      .target(target), .pc_value(pc_value), .fetch_addr(fetch_addr)
   );

   task automatic check(string req, logic [PC_W-1:0] got, logic [PC_W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic check_outs(string req);
      check(req, pc_value, exp_pc);
      check({req, "/R2 fetch"}, PC_W'(fetch_addr), exp_pc & PC_W'(13'h07FF));
   endtask

   task automatic model_reset();
      exp_pc = '0;
      msp = 0;
      for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
   endtask

   task automatic m_push(logic [PC_W-1:0] v);
      mdl[msp] = v;
      msp = (msp + 1) % DEPTH;
   endtask

   // apply one set of strobes for one edge, update the model, check at the next negedge
   task automatic op(string req, bit s, bit j, bit c, bit r, bit i, logic [PC_W-1:0] t);
      step_en = s; jump_en = j; call_en = c; ret_en = r; irq_ack = i; target = t;
      if (i) begin m_push(exp_pc); exp_pc = 13'h0004; end
      else if (r) begin msp = (msp + DEPTH - 1) % DEPTH; exp_pc = mdl[msp]; end
      else if (c) begin m_push(exp_pc + 13'd1); exp_pc = t; end
      else if (j) exp_pc = t;
      else if (s) exp_pc = exp_pc + 13'd1;
      @(negedge clk);
      step_en = 0; jump_en = 0; call_en = 0; ret_en = 0; irq_ack = 0;
      check_outs(req);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      model_reset();
      check_outs("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(4 * 190000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();

      // R1: return straight after reset reads a cleared slot
      op("R1 pop after reset", 0, 0, 0, 1, 0, '0);

      // R3, R2: full sweep including the rollover 1FFFh -> 0000h
      for (int k = 0; k < 8200; k++) op("R3 step sweep", 1, 0, 0, 0, 0, '0);

      // R10: idle cycles hold the counter
      for (int k = 0; k < 4; k++) op("R10 hold", 0, 0, 0, 0, 0, 13'h1555);

      // R4, R2: jumps above the implemented space
      op("R4 jump", 0, 1, 0, 0, 0, 13'h1ABC);
      op("R4 jump", 0, 1, 0, 0, 0, 13'h0800);
      op("R4 jump", 0, 1, 0, 0, 0, 13'h1FFF);
      op("R3 step wrap", 1, 0, 0, 0, 0, '0);

      // R5: interrupt then return
      op("R4 jump", 0, 1, 0, 0, 0, 13'h0123);
      op("R5 irq vector", 0, 0, 0, 0, 1, '0);
      op("R5 irq return", 0, 0, 0, 1, 0, '0);

      // R6, R7: calls nested 8 deep, then unwind
      do_reset();
      for (int d = 0; d < DEPTH; d++) begin
         op("R3 step", 1, 0, 0, 0, 0, '0);
         op("R6 call", 0, 0, 1, 0, 0, PC_W'(13'h0A00 + 13'h0211 * d));
      end
      for (int d = 0; d < DEPTH; d++) op("R7 nested return", 0, 0, 0, 1, 0, '0);

      // R6: call from 1FFFh saves 0000h
      op("R4 jump", 0, 1, 0, 0, 0, 13'h1FFF);
      op("R6 call wrap", 0, 0, 1, 0, 0, 13'h0040);
      op("R7 return wrap", 0, 0, 0, 1, 0, '0);

      // R8: nine saves, then returns past empty
      do_reset();
      for (int d = 0; d < DEPTH + 1; d++)
         op("R8 overflow call", 0, 0, 1, 0, 0, PC_W'(13'h0100 * (d + 1) + d));
      for (int d = 0; d < DEPTH + 2; d++) op("R8 overflow return", 0, 0, 0, 1, 0, '0);

      // R9: simultaneous strobes
      do_reset();
      op("R4 jump", 0, 1, 0, 0, 0, 13'h0333);
      op("R9 irq wins", 1, 1, 1, 1, 1, 13'h0777);
      op("R9 ret over call", 1, 1, 1, 1, 0, 13'h0666);
      op("R9 call over jump", 1, 1, 1, 0, 0, 13'h0555);
      op("R9 ret check", 0, 0, 0, 1, 0, '0);
      op("R9 jump over step", 1, 1, 0, 0, 0, 13'h0444);

      // R1: reset overrides strobes and clears the stack
      op("R6 call", 0, 0, 1, 0, 0, 13'h0999);
      step_en = 1; call_en = 1; irq_ack = 1; target = 13'h0abc;
      rst_n = 1'b0;
      @(negedge clk);
      model_reset();
      check_outs("R1 reset over strobes");
      step_en = 0; call_en = 0; irq_ack = 0;
      rst_n = 1'b1;
      @(negedge clk);
      op("R1 stack cleared", 0, 0, 0, 1, 0, '0);

      finish_run();
   end

endmodule